// File: doc/BRIEF.md
# I2C Master Byte Engine with Software Wait Control

This block is the byte-level sequencer of a single-master I2C controller, reached through a small register bank. Software writes a control word to enable the unit. It then pulses trigger bits to put a start, a repeated start or a stop condition on the bus. A byte goes out when software writes it to the data register, and a received byte is read back from the same register. After each byte the engine parks the bus with SCL held low, raises a one-cycle interrupt and waits until software tells it to continue.

The SCL waveform is paced by an external phase tick. Each tick ends one half-period: low phase, then high phase. The engine never advances a bus phase on its own, so bit timing belongs entirely to a separate timing generator.

The first byte written after a start is the address byte. Its least significant bit sets the direction of the rest of the transfer. In a read, software picks where the engine stops with a control bit. It can stop after the 8th clock, to read the byte before deciding on ACK, or after the 9th. A second control bit decides whether the engine drives ACK or leaves NACK on the 9th clock.

States: `ST_IDLE`, `ST_START`, `ST_PARK`, `ST_BIT_LO`, `ST_BIT_HI`, `ST_ACK_LO`, `ST_ACK_HI`, `ST_WAIT8`, `ST_WAIT9`, `ST_RS_LO`, `ST_RS_HI`, `ST_STP_LO`, `ST_STP_HI`.

Transitions:
- `ST_IDLE`→`ST_START` on a start trigger.
- `ST_START`→`ST_PARK` on a tick.
- `ST_PARK`→`ST_BIT_LO` on a data write.
- `ST_PARK` or `ST_WAIT9`→`ST_STP_LO` on a stop trigger.
- `ST_PARK` or `ST_WAIT9`→`ST_RS_LO` on a start trigger.
- `ST_BIT_LO`→`ST_BIT_HI` on a tick.
- `ST_BIT_HI`→`ST_BIT_LO` on a tick before the last bit.
- `ST_BIT_HI`→`ST_WAIT8` on the last bit of a read with 8th-clock timing.
- `ST_BIT_HI`→`ST_ACK_LO` on the last bit otherwise.
- `ST_ACK_LO`→`ST_ACK_HI` on a tick.
- `ST_ACK_HI`→`ST_BIT_LO` in a read with 8th-clock timing.
- `ST_ACK_HI`→`ST_WAIT9` otherwise.
- `ST_WAIT8`→`ST_ACK_LO` on release.
- `ST_WAIT9`→`ST_BIT_LO` on release in a read.
- `ST_WAIT9`→`ST_BIT_LO` on a data write in a write transfer.
- `ST_RS_LO`→`ST_RS_HI`→`ST_START` on ticks.
- `ST_STP_LO`→`ST_STP_HI`→`ST_IDLE` on ticks.
- Any state→`ST_IDLE` when the unit is disabled.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, SCL and SDA are released (1), irq is 0, and the status (offset 0x10) and control (offset 0x08) registers read 0.
- R2: With the unit enabled (control bit 7), writing 1 to trigger bit 1 (offset 0x0C) while idle drives SDA low with SCL high and sets the busy flag (status bit 6). The next tick pulls SCL low while SDA stays low.
- R3: Writing a byte to offset 0x00 while parked after a start, or in the 9th-clock wait of a write transfer, shifts it out MSB first. Each bit is driven with SCL low for one tick and held with SCL high for one tick. On the 9th clock SDA is released, and status bit 8 is set to 1 when SDA is low at the end of the 9th high phase (0 otherwise).
- R4: irq is high for exactly one cycle when a wait state is entered. In a wait state SCL stays low and the bus does not move on ticks.
- R5: Bit 0 of the first byte after a (repeated) start selects a read when 1. In a read, trigger bit 2 in the 9th-clock wait receives 8 bits with SDA released, sampled at the end of each high phase, MSB first, readable at offset 0x00. Data writes are ignored in a read.
- R6: With control bit 1 = 0 in a read, the engine waits after the 8th clock with an irq. Release then runs the 9th clock and goes straight into the next byte without an irq. With control bit 1 = 1 it waits only after the 9th clock.
- R7: In a read, the 9th-clock SDA is driven low when control bit 0 is 1 and released (NACK) when it is 0.
- R8: Trigger bit 0 in the park or 9th-clock wait state drives SDA low with SCL low, then releases SCL, then releases SDA while SCL is high. This clears busy and sets the stop flag (status bit 4), which the next start clears.
- R9: Trigger bit 1 in the 9th-clock wait releases SDA with SCL low, releases SCL, then pulls SDA low while SCL is high. Busy stays set.
- R10: Triggers are ignored while a bit is being shifted and whenever the unit is disabled.
- R11: Clearing control bit 7 returns the engine to idle within two clocks, with both lines released and all status flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| phase_tick | input | 1 | End of one SCL half-period from the timing generator |
| sda_in | input | 1 | Sampled SDA line level |
| scl_out | output | 1 | SCL open-drain control, 1 = released |
| sda_out | output | 1 | SDA open-drain control, 1 = released |
| irq | output | 1 | One-cycle interrupt on entry into a wait state |

## Verification
A register write or trigger takes effect at the clock edge that captures it, so the bus lines show the new state one clock later. A phase tick moves the lines in the cycle after the tick, and irq rises in that same cycle and falls one clock later. Disabling takes two clocks: one for the control register and one for the engine to reach idle. The bench keeps an expected level for SCL, SDA and irq, updates it together with each stimulus, and compares all three on every falling clock edge, half a period after the edge that should have produced them. Register contents are read combinationally between edges.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_PARK,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_WAIT8,
        ST_WAIT9,
        ST_RS_LO,
        ST_RS_HI,
        ST_STP_LO,
        ST_STP_HI
    } bstate_e;

    // register offsets decoded by software
    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_TRIG = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h10;

    // control bits
    localparam int CTL_EN   = 7;
    localparam int CTL_LATE = 1;
    localparam int CTL_ACK  = 0;

    // trigger bits
    localparam int TRG_REL = 2;
    localparam int TRG_STA = 1;
    localparam int TRG_STP = 0;

    // status bits
    localparam int STS_ACK  = 8;
    localparam int STS_BUSY = 6;
    localparam int STS_STOP = 4;

endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              st_ack,
    input  logic              st_busy,
    input  logic              st_stop,
    output logic              en,
    output logic              late_irq,
    output logic              ack_en,
    output logic              trig_rel,
    output logic              trig_start,
    output logic              trig_stop,
    output logic              data_wr,
    output logic [BYTE_W-1:0] data_byte
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic trig_wr;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            late_irq <= 1'b0;
            ack_en   <= 1'b0;
        end else if (we && addr == A_CTRL) begin
            en       <= wdata[CTL_EN];
            late_irq <= wdata[CTL_LATE];
            ack_en   <= wdata[CTL_ACK];
        end
    end

    assign trig_wr    = we && (addr == A_TRIG) && en;
    assign trig_rel   = trig_wr && wdata[TRG_REL];
    assign trig_start = trig_wr && wdata[TRG_STA];
    assign trig_stop  = trig_wr && wdata[TRG_STP];
    assign data_wr    = we && (addr == A_DATA) && en;
    assign data_byte  = wdata[BYTE_W-1:0];

    always_comb begin
        rdata = '0;
        if (addr == A_DATA) begin
            rdata[BYTE_W-1:0] = rx_byte;
        end else if (addr == A_CTRL) begin
            rdata[CTL_EN]   = en;
            rdata[CTL_LATE] = late_irq;
            rdata[CTL_ACK]  = ack_en;
        end else if (addr == A_STAT) begin
            rdata[STS_ACK]  = st_ack;
            rdata[STS_BUSY] = st_busy;
            rdata[STS_STOP] = st_stop;
        end
    end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              late_irq,
    input  logic              ack_en,
    input  logic              trig_rel,
    input  logic              trig_start,
    input  logic              trig_stop,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              tick,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              irq,
    output logic [BYTE_W-1:0] shreg,
    output logic              ack_flag,
    output logic              busy,
    output logic              stop_flag
);

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    bstate_e          state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             rx_mode;
    logic             addr_byte;
    logic             go_stop, go_start, go_rel;
    logic             rxb, last_bit;

    assign go_stop  = trig_stop;
    assign go_start = trig_start && !trig_stop;
    assign go_rel   = trig_rel && !trig_start && !trig_stop;
    assign rxb      = rx_mode && !addr_byte;
    assign last_bit = (cnt == LAST);

    // next state
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (go_start) nxt = ST_START;
                ST_START:  if (tick) nxt = ST_PARK;
                ST_PARK: begin
                    if (go_stop)       nxt = ST_STP_LO;
                    else if (go_start) nxt = ST_RS_LO;
                    else if (data_wr)  nxt = ST_BIT_LO;
                end
                ST_BIT_LO: if (tick) nxt = ST_BIT_HI;
                ST_BIT_HI: begin
                    if (tick) begin
                        if (!last_bit)               nxt = ST_BIT_LO;
                        else if (rxb && !late_irq)   nxt = ST_WAIT8;
                        else                         nxt = ST_ACK_LO;
                    end
                end
                ST_ACK_LO: if (tick) nxt = ST_ACK_HI;
                ST_ACK_HI: begin
                    if (tick) nxt = (rxb && !late_irq) ? ST_BIT_LO : ST_WAIT9;
                end
                ST_WAIT8:  if (go_rel) nxt = ST_ACK_LO;
                ST_WAIT9: begin
                    if (go_stop)                    nxt = ST_STP_LO;
                    else if (go_start)              nxt = ST_RS_LO;
                    else if (rxb && go_rel)         nxt = ST_BIT_LO;
                    else if (!rx_mode && data_wr)   nxt = ST_BIT_LO;
                end
                ST_RS_LO:  if (tick) nxt = ST_RS_HI;
                ST_RS_HI:  if (tick) nxt = ST_START;
                ST_STP_LO: if (tick) nxt = ST_STP_HI;
                ST_STP_HI: if (tick) nxt = ST_IDLE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            rx_mode   <= 1'b0;
            addr_byte <= 1'b0;
            busy      <= 1'b0;
            stop_flag <= 1'b0;
            ack_flag  <= 1'b0;
            irq       <= 1'b0;
        end else if (!en) begin
            cnt       <= '0;
            rx_mode   <= 1'b0;
            addr_byte <= 1'b0;
            busy      <= 1'b0;
            stop_flag <= 1'b0;
            ack_flag  <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go_start) begin
                        busy      <= 1'b1;
                        stop_flag <= 1'b0;
                    end
                end
                ST_PARK: begin
                    if (!go_stop && !go_start && data_wr) begin
                        shreg     <= data_in;
                        rx_mode   <= data_in[0];
                        addr_byte <= 1'b1;
                        cnt       <= '0;
                    end
                end
                ST_BIT_HI: begin
                    if (tick) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_in};
                        if (last_bit) begin
                            cnt <= '0;
                            if (rxb && !late_irq) irq <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ACK_HI: begin
                    if (tick) begin
                        if (!rxb) ack_flag <= !sda_in;
                        addr_byte <= 1'b0;
                        if (!(rxb && !late_irq)) irq <= 1'b1;
                    end
                end
                ST_WAIT9: begin
                    if (!go_stop && !go_start && !rx_mode && data_wr) begin
                        shreg <= data_in;
                    end
                end
                ST_STP_HI: begin
                    if (tick) begin
                        busy      <= 1'b0;
                        stop_flag <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // line outputs
    always_comb begin
        scl_o = 1'b1;
        sda_o = 1'b1;
        unique case (state)
            ST_IDLE:   begin scl_o = 1'b1; sda_o = 1'b1; end
            ST_START:  begin scl_o = 1'b1; sda_o = 1'b0; end
            ST_PARK:   begin scl_o = 1'b0; sda_o = 1'b0; end
            ST_BIT_LO: begin scl_o = 1'b0; sda_o = rxb ? 1'b1 : shreg[BYTE_W-1]; end
            ST_BIT_HI: begin scl_o = 1'b1; sda_o = rxb ? 1'b1 : shreg[BYTE_W-1]; end
            ST_ACK_LO: begin scl_o = 1'b0; sda_o = rxb ? !ack_en : 1'b1; end
            ST_ACK_HI: begin scl_o = 1'b1; sda_o = rxb ? !ack_en : 1'b1; end
            ST_WAIT8:  begin scl_o = 1'b0; sda_o = 1'b1; end
            ST_WAIT9:  begin scl_o = 1'b0; sda_o = 1'b1; end
            ST_RS_LO:  begin scl_o = 1'b0; sda_o = 1'b1; end
            ST_RS_HI:  begin scl_o = 1'b1; sda_o = 1'b1; end
            ST_STP_LO: begin scl_o = 1'b0; sda_o = 1'b0; end
            ST_STP_HI: begin scl_o = 1'b1; sda_o = 1'b0; end
            default:   begin scl_o = 1'b1; sda_o = 1'b1; end
        endcase
    end

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT8 || state == ST_WAIT9) && en && !trig_rel
         && !trig_start && !trig_stop && !data_wr) |=> ($stable(state) && !scl_o));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en && trig_start) |=> (busy && scl_o && !sda_o));

    // R8
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STP_HI && tick && en) |=> (stop_flag && !busy && sda_o && scl_o));

    // R10
    shift_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_LO && en && !tick) |=> (state == ST_BIT_LO));

    // R11
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && !busy && !stop_flag && !ack_flag));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              phase_tick,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_out,
    output logic              irq
);

    logic              en, late_irq, ack_en;
    logic              trig_rel, trig_start, trig_stop, data_wr;
    logic [BYTE_W-1:0] data_byte, shreg;
    logic              ack_flag, busy, stop_flag;

    i2cm_regs #(
        .ADDR_W(ADDR_W),
        .REG_W (REG_W),
        .BYTE_W(BYTE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .rx_byte   (shreg),
        .st_ack    (ack_flag),
        .st_busy   (busy),
        .st_stop   (stop_flag),
        .en        (en),
        .late_irq  (late_irq),
        .ack_en    (ack_en),
        .trig_rel  (trig_rel),
        .trig_start(trig_start),
        .trig_stop (trig_stop),
        .data_wr   (data_wr),
        .data_byte (data_byte)
    );

    i2cm_engine #(
        .BYTE_W(BYTE_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .late_irq  (late_irq),
        .ack_en    (ack_en),
        .trig_rel  (trig_rel),
        .trig_start(trig_start),
        .trig_stop (trig_stop),
        .data_wr   (data_wr),
        .data_in   (data_byte),
        .tick      (phase_tick),
        .sda_in    (sda_in),
        .scl_o     (scl_out),
        .sda_o     (sda_out),
        .irq       (irq),
        .shreg     (shreg),
        .ack_flag  (ack_flag),
        .busy      (busy),
        .stop_flag (stop_flag)
    );

endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;

    localparam int CLK_PERIOD = 10;
    localparam int A_DATA = 'h00;
    localparam int A_CTRL = 'h08;
    localparam int A_TRIG = 'h0C;
    localparam int A_STAT = 'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        phase_tick = 1'b0;
    logic        sda_in;
    logic        scl_out, sda_out, irq;
    logic        slv = 1'b1;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    exp_scl = 1'b1;
    bit    exp_sda = 1'b1;
    bit    irq_due = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_in = sda_out & slv;

    i2c_byte_master u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .phase_tick(phase_tick),
        .sda_in    (sda_in),
        .scl_out   (scl_out),
        .sda_out   (sda_out),
        .irq       (irq)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // one clock; reference levels compared on every falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        check(cur_req, "scl", int'(scl_out), int'(exp_scl));
        check(cur_req, "sda", int'(sda_out), int'(exp_sda));
        check(cur_req, "irq", int'(irq), int'(irq_due));
        reg_we     = 1'b0;
        phase_tick = 1'b0;
        irq_due    = 1'b0;
    endtask

    task automatic wr(input int a, input int d, input bit es, input bit ed);
        reg_we    = 1'b1;
        reg_addr  = a[5:0];
        reg_wdata = d[15:0];
        exp_scl   = es;
        exp_sda   = ed;
        cyc();
    endtask

    task automatic tk(input bit es, input bit ed, input bit ei);
        phase_tick = 1'b1;
        exp_scl    = es;
        exp_sda    = ed;
        irq_due    = ei;
        cyc();
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = a[5:0];
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic tx_byte(input logic [7:0] b, input bit ack, input bit poke);
        wr(A_DATA, int'(b), 1'b0, b[7]);
        if (poke) begin
            // R10: stop trigger during shifting must be ignored
            wr(A_TRIG, 'h1, 1'b0, b[7]);
        end
        for (int i = 7; i >= 0; i--) begin
            tk(1'b1, b[i], 1'b0);
            if (i > 0) tk(1'b0, b[i-1], 1'b0);
            else       tk(1'b0, 1'b1, 1'b0);
        end
        slv = !ack;
        tk(1'b1, 1'b1, 1'b0);
        tk(1'b0, 1'b1, 1'b1);
        slv = 1'b1;
    endtask

    task automatic rx_bits(input logic [7:0] b, input bit stop8, input bit ackdrv);
        for (int i = 7; i >= 0; i--) begin
            slv = b[i];
            tk(1'b1, 1'b1, 1'b0);
            if (i > 0)      tk(1'b0, 1'b1, 1'b0);
            else if (stop8) tk(1'b0, 1'b1, 1'b1);
            else            tk(1'b0, ackdrv, 1'b0);
        end
        slv = 1'b1;
    endtask

    task automatic ack_clk(input bit ackdrv, input bit to9);
        tk(1'b1, ackdrv, 1'b0);
        tk(1'b0, 1'b1, to9);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        cyc();
        rd(A_STAT, v); check("R1", "status", v, 0);
        rd(A_CTRL, v); check("R1", "control", v, 0);

        cur_req = "R10";
        wr(A_TRIG, 'h2, 1'b1, 1'b1);
        cyc();
        rd(A_STAT, v); check("R10", "busy while disabled", (v >> 6) & 1, 0);

        cur_req = "R2";
        wr(A_CTRL, 'h83, 1'b1, 1'b1);
        wr(A_TRIG, 'h2, 1'b1, 1'b0);
        rd(A_STAT, v); check("R2", "busy", (v >> 6) & 1, 1);
        tk(1'b0, 1'b0, 1'b0);

        cur_req = "R3";
        tx_byte(8'hA4, 1'b1, 1'b0);
        rd(A_STAT, v); check("R3", "ack flag", (v >> 8) & 1, 1);

        cur_req = "R4";
        repeat (3) tk(1'b0, 1'b1, 1'b0);

        cur_req = "R5";
        wr(A_TRIG, 'h4, 1'b0, 1'b1);

        cur_req = "R3";
        tx_byte(8'h3C, 1'b0, 1'b0);
        rd(A_STAT, v); check("R3", "nack flag", (v >> 8) & 1, 0);

        cur_req = "R10";
        tx_byte(8'h81, 1'b1, 1'b1);

        cur_req = "R9";
        wr(A_TRIG, 'h2, 1'b0, 1'b1);
        tk(1'b1, 1'b1, 1'b0);
        tk(1'b1, 1'b0, 1'b0);
        tk(1'b0, 1'b0, 1'b0);
        rd(A_STAT, v); check("R9", "busy kept", (v >> 6) & 1, 1);

        cur_req = "R5";
        tx_byte(8'hA5, 1'b1, 1'b0);
        wr(A_DATA, 'h77, 1'b0, 1'b1);
        wr(A_TRIG, 'h4, 1'b0, 1'b1);
        rx_bits(8'h5A, 1'b0, 1'b0);
        ack_clk(1'b0, 1'b1);
        rd(A_DATA, v); check("R5", "rx byte", v, 'h5A);

        cur_req = "R6";
        wr(A_CTRL, 'h81, 1'b0, 1'b1);
        wr(A_TRIG, 'h4, 1'b0, 1'b1);
        rx_bits(8'hC3, 1'b1, 1'b0);
        rd(A_DATA, v); check("R6", "rx byte at 8th", v, 'hC3);
        tk(1'b0, 1'b1, 1'b0);
        wr(A_TRIG, 'h4, 1'b0, 1'b0);
        ack_clk(1'b0, 1'b0);
        rx_bits(8'h96, 1'b1, 1'b0);
        rd(A_DATA, v); check("R6", "second rx byte", v, 'h96);

        cur_req = "R7";
        wr(A_CTRL, 'h80, 1'b0, 1'b1);
        wr(A_CTRL, 'h82, 1'b0, 1'b1);
        wr(A_TRIG, 'h4, 1'b0, 1'b1);
        ack_clk(1'b1, 1'b1);

        cur_req = "R8";
        wr(A_TRIG, 'h1, 1'b0, 1'b0);
        tk(1'b1, 1'b0, 1'b0);
        tk(1'b1, 1'b1, 1'b0);
        rd(A_STAT, v);
        check("R8", "busy cleared", (v >> 6) & 1, 0);
        check("R8", "stop flag", (v >> 4) & 1, 1);
        wr(A_TRIG, 'h2, 1'b1, 1'b0);
        rd(A_STAT, v); check("R8", "stop flag cleared by start", (v >> 4) & 1, 0);
        tk(1'b0, 1'b0, 1'b0);

        cur_req = "R11";
        wr(A_CTRL, 'h0, 1'b0, 1'b0);
        exp_scl = 1'b1;
        exp_sda = 1'b1;
        cyc();
        rd(A_STAT, v); check("R11", "status after disable", v, 0);

        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule